// File: doc/BRIEF.md
# I2C Register-Mapped Status Target

This block is an I2C target that lets a host processor read and update a small bank of byte-wide registers over a two-wire bus. It sits behind fixed 7-bit address 0x30 and serves five registers: a read/write byte that drives a user LED, a read-only boot-variant code, two read-only revision bytes and a status byte that carries a live interrupt input from a real-time clock.

The bus lines are brought into the block's clock domain through short synchroniser chains. START and STOP are recognised from SDA edges while SCL is high. Address bits, data bits and acknowledges are handled by one state machine that holds an internal register pointer. In a write transaction the first data byte sets the pointer and later bytes store at the pointer. Each data byte moves the pointer on by one, in writes and in reads alike. The block only ever pulls SDA low. It never stretches the clock and does not answer the general call.

Top module: `i2c_status_target`

## Requirements
- R1: The target acknowledges (holds SDA low through the ninth SCL pulse) an address byte whose upper seven bits equal 0x30. Any other address is not acknowledged. After that the target drives nothing and changes no register until the next START.
- R2: In a write transaction the first data byte loads the register pointer. Each following byte is stored at the pointer, and the pointer then increments and wraps from 0xFF to 0x00. Every data byte is acknowledged.
- R3: Index 0x00 is the user LED byte. It is readable and writable, and its value appears on `led_ctrl_o`.
- R4: Index 0x01 reads 0x01. Indices 0x02 and 0x03 read 0x03.
- R5: Index 0x04 reads the synchronised RTC interrupt input in bit 4. The other seven bits read zero.
- R6: A write to any index other than 0x00 is acknowledged and has no effect. Indices 0x05 to 0xFF read 0x00.
- R7: A read transaction returns the byte at the pointer, sent MSB first, and the pointer advances by one after each byte. A master ACK (SDA low on the ninth pulse) requests the next byte. A NACK ends the read, and SDA is released.
- R8: An SDA fall while SCL is high is a START: a repeated START restarts the address phase. An SDA rise while SCL is high is a STOP and returns the target to idle. The pointer keeps its value across transactions.
- R9: SDA is only ever pulled low, never driven high. The pull is only applied or changed after a detected SCL falling edge.
- R10: After reset SDA is released, the pointer is 0x00 and the LED byte is 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain enable) |
| rtc_irq_i | input | 1 | RTC interrupt level, read through index 0x04 bit 4 |
| led_ctrl_o | output | 8 | Current contents of the user LED register |

## Verification
On every cycle, assertions in the RTL check these rules:
- The SDA pull only turns on right after a detected SCL fall.
- The idle state holds SDA released and is left only through a START.
- A write to a read-only index leaves the LED byte unchanged.
- Indices above 0x04 read zero.

Other behaviours can only be shown by the bench's transactions. These include:
- whether the address comparison really selects 0x30;
- the pointer-then-data write semantics and the auto-increment with wrap;
- the exact read contents at each index, with the RTC bit in both states;
- repeated START, and silence after a foreign address.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned REG_COUNT = 5;
  localparam int unsigned IRQ_BIT   = 4;

  localparam logic [BYTE_W-1:0] LED_RESET      = 8'h01;
  localparam logic [BYTE_W-1:0] BOOTVAR_CODE   = 8'h01;
  localparam logic [BYTE_W-1:0] FW_REV_CODE    = 8'h03;
  localparam logic [BYTE_W-1:0] BOARD_REV_CODE = 8'h03;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WR,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_low_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic              rw_q, rw_d;
  logic              ph_q, ph_d;
  logic              first_q, first_d;
  logic              sda_low_q, sda_low_d;
  logic [BYTE_W-1:0] rx_byte;

  assign rx_byte = {shreg_q[BYTE_W-2:0], sda_s};

  always_comb begin
    state_d   = state_q;
    bitcnt_d  = bitcnt_q;
    shreg_d   = shreg_q;
    ptr_d     = ptr_q;
    rw_d      = rw_q;
    ph_d      = ph_q;
    first_d   = first_q;
    sda_low_d = sda_low_q;
    wr_en_o   = 1'b0;
    if (stop_i) begin
      state_d   = ST_IDLE;
      sda_low_d = 1'b0;
    end else if (start_i) begin
      state_d   = ST_ADDR;
      bitcnt_d  = '0;
      first_d   = 1'b1;
      sda_low_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: if (scl_rise_i) begin
          shreg_d  = rx_byte;
          bitcnt_d = bitcnt_q + 1'b1;
          if (bitcnt_q == LAST_BIT) begin
            if (shreg_q[6:0] == TGT_ADDR) begin
              state_d = ST_ACK;
              rw_d    = sda_s;
              ph_d    = 1'b0;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ACK: if (scl_fall_i) begin
          if (!ph_q) begin
            sda_low_d = 1'b1;
            ph_d      = 1'b1;
          end else begin
            ph_d     = 1'b0;
            bitcnt_d = '0;
            if (rw_q) begin
              state_d   = ST_RD;
              shreg_d   = rd_data_i;
              sda_low_d = ~rd_data_i[BYTE_W-1];
            end else begin
              state_d   = ST_WR;
              sda_low_d = 1'b0;
            end
          end
        end
        ST_WR: if (scl_rise_i) begin
          shreg_d  = rx_byte;
          bitcnt_d = bitcnt_q + 1'b1;
          if (bitcnt_q == LAST_BIT) begin
            state_d = ST_ACK;
            ph_d    = 1'b0;
            if (first_q) begin
              ptr_d   = rx_byte;
              first_d = 1'b0;
            end else begin
              wr_en_o = 1'b1;
              ptr_d   = ptr_q + 1'b1;
            end
          end
        end
        ST_RD: begin
          if (scl_rise_i) begin
            bitcnt_d = bitcnt_q + 1'b1;
            if (bitcnt_q == LAST_BIT) begin
              state_d = ST_RD_ACK;
              ph_d    = 1'b0;
            end
          end
          if (scl_fall_i) begin
            shreg_d   = {shreg_q[BYTE_W-2:0], 1'b0};
            sda_low_d = ~shreg_q[BYTE_W-2];
          end
        end
        ST_RD_ACK: begin
          if (scl_fall_i) begin
            if (!ph_q) begin
              sda_low_d = 1'b0;
              ph_d      = 1'b1;
            end else begin
              state_d   = ST_RD;
              bitcnt_d  = '0;
              shreg_d   = rd_data_i;
              sda_low_d = ~rd_data_i[BYTE_W-1];
            end
          end else if (scl_rise_i && ph_q) begin
            ptr_d = ptr_q + 1'b1;
            if (sda_s) state_d = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bitcnt_q  <= '0;
      shreg_q   <= '0;
      ptr_q     <= '0;
      rw_q      <= 1'b0;
      ph_q      <= 1'b0;
      first_q   <= 1'b0;
      sda_low_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      bitcnt_q  <= bitcnt_d;
      shreg_q   <= shreg_d;
      ptr_q     <= ptr_d;
      rw_q      <= rw_d;
      ph_q      <= ph_d;
      first_q   <= first_d;
      sda_low_q <= sda_low_d;
    end
  end

  assign ptr_o     = ptr_q;
  assign wr_data_o = rx_byte;
  assign sda_low_o = sda_low_q;

  // R9: the pull turns on only in the cycle after a detected SCL fall
  assert_drive_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low_q) |-> $past(scl_fall_i));

  // R1: the idle target keeps SDA released
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_low_q);

  // R1 / R8: idle is left only through a START
  assert_idle_until_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/i2c_tgt_regfile.sv
module i2c_tgt_regfile
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] idx_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              irq_s,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [BYTE_W-1:0] led_o
);
  logic [BYTE_W-1:0] led_q, led_d;
  logic              led_we;
  logic [REG_COUNT-1:0][BYTE_W-1:0] bank;

  always_comb begin
    led_we = wr_en_i && (idx_i == '0);
    led_d  = led_we ? wr_data_i : led_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_q <= LED_RESET;
    else        led_q <= led_d;
  end

  always_comb begin
    bank          = '0;
    bank[0]       = led_q;
    bank[1]       = BOOTVAR_CODE;
    bank[2]       = FW_REV_CODE;
    bank[3]       = BOARD_REV_CODE;
    bank[4][IRQ_BIT] = irq_s;
    rd_data_o = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (idx_i == BYTE_W'(i)) rd_data_o = bank[i];
    end
  end

  assign led_o = led_q;

  // R6: writes to read-only indices leave the LED byte untouched
  assert_ro_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && idx_i != '0) |=> $stable(led_q));

  // R3: a write at index zero lands in the LED byte on the next cycle
  assert_led_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && idx_i == '0) |=> (led_q == $past(wr_data_i)));

  // R6: indices past the map read as zero
  assert_hi_index_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_i >= BYTE_W'(REG_COUNT)) |-> (rd_data_o == '0));
endmodule

// File: rtl/i2c_status_target.sv
module i2c_status_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  TGT_ADDR    = 7'h30,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              rtc_irq_i,
  output logic [BYTE_W-1:0] led_ctrl_o
);
  localparam int unsigned     NLINES   = 3;
  localparam logic [NLINES-1:0] LINE_RST = 3'b011;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [NLINES-1:0] lines_raw, lines_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] ptr, wr_data, rd_data;
  logic              wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign lines_raw = {rtc_irq_i, sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LINE_RST[g])) u_sync (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .din  (lines_raw[g]),
      .dout (lines_s[g])
    );
  end

  i2c_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_s    (lines_s[0]),
    .sda_s    (lines_s[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_tgt_engine #(.TGT_ADDR(TGT_ADDR)) u_engine (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sda_s     (lines_s[1]),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .rd_data_i (rd_data),
    .ptr_o     (ptr),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .sda_low_o (sda_pull_o)
  );

  i2c_tgt_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .idx_i    (ptr),
    .wr_en_i  (wr_en),
    .wr_data_i(wr_data),
    .irq_s    (lines_s[2]),
    .rd_data_o(rd_data),
    .led_o    (led_ctrl_o)
  );
endmodule

// File: tb/tb_i2c_status_target.sv
`timescale 1ns/1ps
module tb_i2c_status_target;
  localparam int Q = 8;

  logic clk, rst_n, scl_m, sda_m, rtc;
  logic sda_pull_o;
  logic [7:0] led_ctrl_o;
  wire sda_line = sda_m & ~sda_pull_o;

  logic may_drive, led_settle, chk_on, done;
  logic [7:0] exp_led, exp_ptr;
  int n_chk, n_fail;

  i2c_status_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .rtc_irq_i(rtc), .led_ctrl_o(led_ctrl_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [7:0] idx);
    case (idx)
      8'h00: return exp_led;
      8'h01: return 8'h01;
      8'h02, 8'h03: return 8'h03;
      8'h04: return {3'b000, rtc, 4'b0000};
      default: return 8'h00;
    endcase
  endfunction

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (chk_on && !done) begin
      if (!led_settle) check(led_ctrl_o == exp_led, "R3 led", led_ctrl_o, exp_led);
      if (!may_drive)  check(!sda_pull_o, "R9 unexpected pull", sda_pull_o, 0);
    end
  end

  task automatic wait_q;
    repeat (Q) @(posedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wait_q; scl_m = 1'b1; wait_q; sda_m = 1'b0; wait_q; scl_m = 1'b0; wait_q;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wait_q; scl_m = 1'b1; wait_q; sda_m = 1'b1; wait_q;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit keep, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q; scl_m = 1'b1; wait_q; wait_q; scl_m = 1'b0;
      if (i == 0) may_drive = 1'b1;
      wait_q;
    end
    sda_m = 1'b1; wait_q; scl_m = 1'b1; wait_q;
    acked = !sda_line;
    wait_q; scl_m = 1'b0; wait_q;
    if (!keep) may_drive = 1'b0;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wait_q; scl_m = 1'b1; wait_q;
      b[i] = sda_line;
      wait_q; scl_m = 1'b0; wait_q;
    end
    may_drive = 1'b0;
    sda_m = ack ? 1'b0 : 1'b1; wait_q; scl_m = 1'b1; wait_q; wait_q; scl_m = 1'b0;
    if (ack) may_drive = 1'b1;
    wait_q;
  endtask

  task automatic addr(input logic [6:0] a, input bit rw, input bit exp_ack, input string req);
    bit ak;
    send_byte({a, rw}, rw && exp_ack, ak);
    check(ak == exp_ack, req, ak, exp_ack);
  endtask

  task automatic wptr(input logic [7:0] p);
    bit ak;
    send_byte(p, 1'b0, ak);
    check(ak, "R2 pointer ack", ak, 1);
    exp_ptr = p;
  endtask

  task automatic wdata(input logic [7:0] d, input string req);
    bit ak;
    led_settle = 1'b1;
    send_byte(d, 1'b0, ak);
    check(ak, req, ak, 1);
    if (exp_ptr == 8'h00) exp_led = d;
    exp_ptr = exp_ptr + 8'd1;
    led_settle = 1'b0;
  endtask

  task automatic rdata(input bit ack, input string req);
    logic [7:0] b, e;
    e = model_read(exp_ptr);
    recv_byte(ack, b);
    check(b == e, req, b, e);
    exp_ptr = exp_ptr + 8'd1;
  endtask

  task automatic send_ignored(input logic [7:0] d);
    bit ak;
    send_byte(d, 1'b0, ak);
    check(!ak, "R1 ignored byte acked", ak, 0);
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0;
    chk_on = 1'b0; may_drive = 1'b0; led_settle = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1; rtc = 1'b0; rst_n = 1'b0;
    exp_led = 8'h01; exp_ptr = 8'h00;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(led_ctrl_o == 8'h01, "R10 reset led", led_ctrl_o, 8'h01);
    check(!sda_pull_o, "R10 reset sda", sda_pull_o, 0);
    rst_n = 1'b1;
    repeat (10) @(posedge clk);
    chk_on = 1'b1;

    // R10 / R7: read right after reset starts at index 0
    bus_start; addr(7'h30, 1'b1, 1'b1, "R1 own address read ack");
    rdata(1'b0, "R10 pointer reset to 0"); bus_stop;

    // R3: write the LED byte
    bus_start; addr(7'h30, 1'b0, 1'b1, "R1 own address write ack");
    wptr(8'h00); wdata(8'hA5, "R3 led write ack"); bus_stop;
    check(led_ctrl_o == 8'hA5, "R3 led value", led_ctrl_o, 8'hA5);

    // R4 R5 R6 R7 R8: repeated START, burst read over the map
    rtc = 1'b1;
    bus_start; addr(7'h30, 1'b0, 1'b1, "R1 ack");
    wptr(8'h01);
    bus_start; addr(7'h30, 1'b1, 1'b1, "R8 repeated start address ack");
    rdata(1'b1, "R4 boot variant");
    rdata(1'b1, "R4 firmware revision");
    rdata(1'b1, "R4 board revision");
    rdata(1'b1, "R5 status irq high");
    rdata(1'b0, "R6 index above map");
    bus_stop;

    // R6: writes to read-only indices are acknowledged and discarded
    bus_start; addr(7'h30, 1'b0, 1'b1, "R1 ack");
    wptr(8'h01); wdata(8'h55, "R6 ro write ack"); wdata(8'h66, "R6 ro write ack");
    bus_stop;
    bus_start; addr(7'h30, 1'b0, 1'b1, "R1 ack"); wptr(8'h01);
    bus_start; addr(7'h30, 1'b1, 1'b1, "R1 ack");
    rdata(1'b1, "R6 index 1 unchanged"); rdata(1'b0, "R6 index 2 unchanged");
    bus_stop;
    check(led_ctrl_o == 8'hA5, "R6 led unchanged", led_ctrl_o, 8'hA5);

    // R1: foreign addresses are ignored until the next START
    bus_start; addr(7'h31, 1'b0, 1'b0, "R1 foreign write nack");
    send_ignored(8'h00); send_ignored(8'h5A); bus_stop;
    check(led_ctrl_o == 8'hA5, "R1 led untouched", led_ctrl_o, 8'hA5);
    bus_start; addr(7'h18, 1'b1, 1'b0, "R1 foreign read nack"); bus_stop;

    // R2: pointer then data, auto-increment past the LED byte
    bus_start; addr(7'h30, 1'b0, 1'b1, "R1 ack");
    wptr(8'h00); wdata(8'h3C, "R2 data ack"); wdata(8'h77, "R2 data ack");
    bus_start; addr(7'h30, 1'b1, 1'b1, "R1 ack");
    rdata(1'b0, "R2 pointer after two writes"); bus_stop;
    bus_start; addr(7'h30, 1'b0, 1'b1, "R1 ack"); wptr(8'h00);
    bus_start; addr(7'h30, 1'b1, 1'b1, "R1 ack");
    rdata(1'b1, "R2 led readback"); rdata(1'b0, "R2 index 1 readback");
    bus_stop;

    // R5: status with irq low
    rtc = 1'b0; repeat (6) @(posedge clk);
    bus_start; addr(7'h30, 1'b0, 1'b1, "R1 ack"); wptr(8'h04);
    bus_start; addr(7'h30, 1'b1, 1'b1, "R1 ack");
    rdata(1'b0, "R5 status irq low"); bus_stop;

    // R8: clocks after STOP without START are ignored; pointer kept across STOP
    scl_m = 1'b0; wait_q;
    send_ignored(8'h60);
    bus_stop;
    bus_start; addr(7'h30, 1'b0, 1'b1, "R1 ack"); wptr(8'h00); bus_stop;
    bus_start; addr(7'h30, 1'b1, 1'b1, "R8 ack after stop");
    rdata(1'b0, "R8 pointer kept across stop"); bus_stop;

    // R2: pointer wrap from 0xFF to 0x00
    bus_start; addr(7'h30, 1'b0, 1'b1, "R1 ack");
    wptr(8'hFF); wdata(8'h11, "R2 write at ff"); wdata(8'h42, "R2 wrapped write");
    bus_stop;
    check(led_ctrl_o == 8'h42, "R2 wrap lands at index 0", led_ctrl_o, 8'h42);

    repeat (20) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule